// File: doc/BRIEF.md
# Readable Memory Bank Register

This block is the bank-select register that an 8-bit processor writes to choose which 32 KB slice of a larger paged RAM appears in the lower half of its 64 KB address space. The register sits on the processor bus at four consecutive offsets. A write on any offset is qualified by the phase-2 bus clock. The data present on the bus during the last system clock of phase-2 is committed when phase-2 falls.

The four offsets let software change the bank in four ways: load a whole byte, OR bits in, clear bits out, or apply a set mask and a clear mask to the bank nibble in one access. A read on any offset returns the whole register, so software never has to keep a private copy of the active bank in RAM. An asynchronous reset puts the system in bank 0, which is the kernel's bank.

The low four register bits become the top four lines of a 19-bit physical address whenever the processor addresses its lower 32 KB. Upper-half addresses are zero-extended unchanged.

Top module: `mbr_top`

## Requirements
- R1: While `rst_n` is low the register reads 0x00 at once, with no clock edge needed, and `bank_o` is 0.
- R2: A write at offset 0 replaces the whole 8-bit register with the written byte.
- R3: A write at offset 1 leaves the register equal to its old value OR the written byte.
- R4: A write at offset 2 leaves the register equal to its old value AND the inverse of the written byte.
- R5: A write at offset 3 keeps register bits 7..4 unchanged. It sets the low-nibble bits named by data bits 7..4, then clears the low-nibble bits named by data bits 3..0, so a bit named in both masks ends at 0.
- R6: The register does not change while `phi2` is high. A write takes effect on the first clock edge at which `phi2` is sampled low after being high. It uses the offset and data sampled at the last edge where `phi2` was high.
- R7: While `phi2` is high, `sel_n` is low and `rnw` is high, `rd_oe` is 1 and `rd_data` equals the whole register, for any of the four offsets. Otherwise `rd_oe` is 0.
- R8: A read access leaves the register unchanged.
- R9: When `cpu_addr[15]` is 0, `phys_addr` equals {bank_o, cpu_addr[14:0]}.
- R10: When `cpu_addr[15]` is 1, `phys_addr` equals {3'b000, cpu_addr}.
- R11: A bus write with `sel_n` high leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phi2 | input | 1 | Phase-2 bus clock level, synchronous to `clk` |
| sel_n | input | 1 | Register select from the address decoder, active low |
| rnw | input | 1 | 1 for a bus read, 0 for a bus write |
| reg_off | input | 2 | Register offset: 0 load, 1 set, 2 clear, 3 mask pair |
| wr_data | input | 8 | Processor write data |
| rd_data | output | 8 | Register value for the read path |
| rd_oe | output | 1 | Enables the tri-state bus driver for `rd_data` |
| cpu_addr | input | 16 | Processor address |
| phys_addr | output | 19 | Physical RAM address |
| bank_o | output | 4 | Active bank number |

## Verification
The assertions take `phi2`, `sel_n`, `rnw`, `reg_off` and `wr_data` to be synchronous to `clk`. They also assume `phi2` stays high and then low for at least one clock each, so that every bus cycle has a phase-2 window the register can see. The bench drives all inputs on the falling edge of `clk`. Each bus access holds `phi2` high for one or two whole clocks and then low for at least one, which keeps the stimulus inside those assumptions.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam int DATA_W = 8;
    localparam int OFF_W  = 2;

    typedef enum logic [OFF_W-1:0] {
        OP_LOAD = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_MASK = 2'd3
    } op_e;

    typedef struct packed {
        logic              valid;
        op_e               op;
        logic [DATA_W-1:0] data;
    } pend_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              phi2;
        pend_t             pend;
    } state_t;

endpackage

// File: rtl/mbr_phase_capture.sv
module mbr_phase_capture
    import mbr_pkg::*;
(
    input  logic              phi2,
    input  logic              phi2_q,
    input  logic              sel_n,
    input  logic              rnw,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0] wr_data,
    input  pend_t             pend_q,
    output pend_t             pend_d,
    output logic              commit
);

    logic falling;

    always_comb begin
        falling = phi2_q && !phi2;
        commit  = falling && pend_q.valid;
        pend_d  = pend_q;
        if (phi2) begin
            // keep only what the bus shows in the latest phase-2 cycle
            pend_d.valid = !sel_n && !rnw;
            pend_d.op    = op_e'(reg_off);
            pend_d.data  = wr_data;
        end else if (falling) begin
            pend_d.valid = 1'b0;
        end
    end

endmodule

// File: rtl/mbr_update.sv
module mbr_update
    import mbr_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic [DATA_W-1:0] cur,
    input  pend_t             req,
    output logic [DATA_W-1:0] nxt
);

    localparam int HALF = DATA_W / 2;

    logic [BANK_W-1:0] low_set;
    logic [BANK_W-1:0] low_clr;

    always_comb begin
        low_set = BANK_W'(req.data[DATA_W-1:HALF]);
        low_clr = BANK_W'(req.data[HALF-1:0]);
        nxt     = cur;
        unique case (req.op)
            OP_LOAD: nxt = req.data;
            OP_SET:  nxt = cur | req.data;
            OP_CLR:  nxt = cur & ~req.data;
            OP_MASK: nxt[BANK_W-1:0] = (cur[BANK_W-1:0] | low_set) & ~low_clr;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/mbr_window.sv
module mbr_window #(
    parameter int BANK_W = 4,
    parameter int WIN_W  = 15,
    parameter int CPU_AW = 16
) (
    input  logic [BANK_W-1:0]       bank,
    input  logic [CPU_AW-1:0]       cpu_addr,
    output logic [BANK_W+WIN_W-1:0] phys_addr
);

    localparam int PHYS_AW = BANK_W + WIN_W;
    localparam int PAD_W   = PHYS_AW - CPU_AW;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb begin
                if (cpu_addr[CPU_AW-1:WIN_W] == '0)
                    phys_addr = {bank, cpu_addr[WIN_W-1:0]};
                else
                    phys_addr = {{PAD_W{1'b0}}, cpu_addr};
            end
        end else begin : g_nopad
            always_comb begin
                if (cpu_addr[CPU_AW-1:WIN_W] == '0)
                    phys_addr = {bank, cpu_addr[WIN_W-1:0]};
                else
                    phys_addr = cpu_addr[PHYS_AW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/mbr_top.sv
module mbr_top
    import mbr_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int WIN_W  = 15,
    parameter int CPU_AW = 16,
    localparam int PHYS_AW = BANK_W + WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi2,
    input  logic               sel_n,
    input  logic               rnw,
    input  logic [OFF_W-1:0]   reg_off,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_oe,
    input  logic [CPU_AW-1:0]  cpu_addr,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic [BANK_W-1:0]  bank_o
);

    state_t            st_d;
    state_t            st_q;
    pend_t             pend_d;
    logic              commit;
    logic [DATA_W-1:0] upd_value;

    mbr_phase_capture i_capture (
        .phi2    (phi2),
        .phi2_q  (st_q.phi2),
        .sel_n   (sel_n),
        .rnw     (rnw),
        .reg_off (reg_off),
        .wr_data (wr_data),
        .pend_q  (st_q.pend),
        .pend_d  (pend_d),
        .commit  (commit)
    );

    mbr_update #(.BANK_W(BANK_W)) i_update (
        .cur (st_q.value),
        .req (st_q.pend),
        .nxt (upd_value)
    );

    mbr_window #(.BANK_W(BANK_W), .WIN_W(WIN_W), .CPU_AW(CPU_AW)) i_window (
        .bank      (st_q.value[BANK_W-1:0]),
        .cpu_addr  (cpu_addr),
        .phys_addr (phys_addr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.phi2 = phi2;
        st_d.pend = pend_d;
        if (commit)
            st_d.value = upd_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_data = st_q.value;
    assign rd_oe   = phi2 && !sel_n && rnw;
    assign bank_o  = st_q.value[BANK_W-1:0];

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
    parameter int BANK_W = 4,
    parameter int WIN_W  = 15,
    parameter int CPU_AW = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      phi2,
    input logic                      sel_n,
    input logic                      rnw,
    input logic [7:0]                rd_data,
    input logic                      rd_oe,
    input logic [CPU_AW-1:0]         cpu_addr,
    input logic [BANK_W+WIN_W-1:0]   phys_addr,
    input logic [BANK_W-1:0]         bank_o
);

    localparam int PAD_W = BANK_W + WIN_W - CPU_AW;

    // R1: reset holds the bank at zero
    a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> (bank_o == '0));

    // R6: nothing commits while phase-2 is high
    a_r6_hold_in_phase2: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |=> $stable(rd_data));

    // R8: a read cycle leaves the register unchanged
    a_r8_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |=> $stable(rd_data));

    // R7: the read path carries the bank held in the register
    a_r7_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (rd_data[BANK_W-1:0] == bank_o));

    // R9: lower window uses the bank
    a_r9_low_window: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[CPU_AW-1] |-> (phys_addr[BANK_W+WIN_W-1:WIN_W] == bank_o));

    // R10: upper window passes through
    a_r10_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[CPU_AW-1] |-> (phys_addr == {{PAD_W{1'b0}}, cpu_addr}));

endmodule

bind mbr_top mbr_checker #(.BANK_W(BANK_W), .WIN_W(WIN_W), .CPU_AW(CPU_AW)) i_mbr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .phi2      (phi2),
    .sel_n     (sel_n),
    .rnw       (rnw),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .cpu_addr  (cpu_addr),
    .phys_addr (phys_addr),
    .bank_o    (bank_o)
);

// File: tb/test_mbr_top.sv
module test_mbr_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic        sel_n = 1'b1;
    logic        rnw = 1'b1;
    logic [1:0]  reg_off = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic        rd_oe;
    logic [15:0] cpu_addr = 16'd0;
    logic [18:0] phys_addr;
    logic [3:0]  bank_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'd0;

    always #5 clk = ~clk;

    mbr_top i_mbr_top (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .sel_n(sel_n), .rnw(rnw),
        .reg_off(reg_off), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .cpu_addr(cpu_addr), .phys_addr(phys_addr), .bank_o(bank_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] apply(input logic [1:0] op, input logic [7:0] q, input logic [7:0] d);
        logic [7:0] r;
        r = q;
        case (op)
            2'd0: r = d;                                   // R2
            2'd1: r = q | d;                               // R3
            2'd2: r = q & ~d;                              // R4
            default: r[3:0] = (q[3:0] | d[7:4]) & ~d[3:0]; // R5
        endcase
        return r;
    endfunction

    task automatic bus_write(input logic [1:0] off, input logic [7:0] d, input logic select);
        @(negedge clk);
        phi2 = 1'b1; sel_n = !select; rnw = 1'b0; reg_off = off; wr_data = d;
        @(negedge clk);
        phi2 = 1'b0; sel_n = 1'b1; rnw = 1'b1;
        @(negedge clk);
        #1;
    endtask

    task automatic bus_read(input logic [1:0] off, input logic [7:0] exp);
        @(negedge clk);
        phi2 = 1'b1; sel_n = 1'b0; rnw = 1'b1; reg_off = off;
        #1;
        check("R7 oe", {31'd0, rd_oe}, 32'd1);
        check("R7 data", {24'd0, rd_data}, {24'd0, exp});
        @(negedge clk);
        phi2 = 1'b0; sel_n = 1'b1;
        #1;
        check("R7 oe off", {31'd0, rd_oe}, 32'd0);
        @(negedge clk);
        #1;
        check("R8 read keeps value", {24'd0, rd_data}, {24'd0, exp});
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        #1;
        check("R1 reset value", {24'd0, rd_data}, 32'd0);
        check("R1 reset bank", {28'd0, bank_o}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // near-exhaustive sweep of all four offsets
        for (int op = 0; op < 4; op++) begin
            for (int s = 0; s < 16; s++) begin
                for (int d = 0; d < 256; d += ((op == 3) ? 1 : 7)) begin
                    logic [7:0] start;
                    start = 8'(s * 17 + 3) ^ 8'(s << 4);
                    bus_write(2'd0, start, 1'b1);
                    check("R2 load", {24'd0, rd_data}, {24'd0, start});
                    bus_write(2'(op), 8'(d), 1'b1);
                    model = apply(2'(op), start, 8'(d));
                    case (op)
                        0: check("R2 load op", {24'd0, rd_data}, {24'd0, model});
                        1: check("R3 set op", {24'd0, rd_data}, {24'd0, model});
                        2: check("R4 clear op", {24'd0, rd_data}, {24'd0, model});
                        default: check("R5 mask op", {24'd0, rd_data}, {24'd0, model});
                    endcase
                end
            end
        end

        // R5 both masks on the same bit: clear wins
        bus_write(2'd0, 8'hA5, 1'b1);
        bus_write(2'd3, 8'hFF, 1'b1);
        check("R5 clear wins", {24'd0, rd_data}, 32'hA0);

        // R7 / R8 read at each offset
        bus_write(2'd0, 8'h5C, 1'b1);
        for (int o = 0; o < 4; o++) bus_read(2'(o), 8'h5C);

        // R11 unselected write ignored
        bus_write(2'd0, 8'h13, 1'b0);
        check("R11 no select", {24'd0, rd_data}, 32'h5C);
        bus_write(2'd1, 8'hFF, 1'b0);
        check("R11 no select set", {24'd0, rd_data}, 32'h5C);

        // R6 timing: two phase-2 cycles with changing data, last one wins
        @(negedge clk);
        phi2 = 1'b1; sel_n = 1'b0; rnw = 1'b0; reg_off = 2'd0; wr_data = 8'h11;
        @(negedge clk);
        #1;
        check("R6 hold while high", {24'd0, rd_data}, 32'h5C);
        wr_data = 8'h77;
        @(negedge clk);
        #1;
        check("R6 hold while high 2", {24'd0, rd_data}, 32'h5C);
        phi2 = 1'b0; sel_n = 1'b1; rnw = 1'b1; wr_data = 8'h00;
        #1;
        check("R6 no change before edge", {24'd0, rd_data}, 32'h5C);
        @(negedge clk);
        #1;
        check("R6 commit last data", {24'd0, rd_data}, 32'h77);
        repeat (2) @(negedge clk);
        #1;
        check("R6 single commit", {24'd0, rd_data}, 32'h77);

        // R9 / R10 address map sweep
        for (int b = 0; b < 16; b++) begin
            bus_write(2'd0, 8'(b) | 8'hF0, 1'b1);
            check("R9 bank out", {28'd0, bank_o}, 32'(b));
            for (int a = 0; a < 65536; a += 4099) begin
                cpu_addr = 16'(a);
                #1;
                if (a < 32768)
                    check("R9 low window", {13'd0, phys_addr}, {13'd0, 4'(b), 15'(a)});
                else
                    check("R10 upper pass", {13'd0, phys_addr}, 32'(a));
            end
        end

        // R1 asynchronous reset mid-run
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        check("R1 async reset", {24'd0, rd_data}, 32'd0);
        check("R1 async bank", {28'd0, bank_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule